// File: doc/BRIEF.md
# Programmable Symbol Injection Controller

This block sits in a transmit path, downstream of the stage that repeats and smooths the outgoing symbol stream, and can overwrite outgoing data symbol pairs with a pair chosen by the host. Each stream beat carries one symbol pair: two 5-bit code groups, with the first symbol in bits 9:5 and the second in bits 4:0. The replacement pair comes from two host-programmed 5-bit inputs. These hold code groups that are already in 5B form and are inserted without any further coding.

The host picks one of four injection modes and an 8-bit threshold, and commits them with a write strobe. In continuous mode every pair is replaced. Periodic mode uses a down-counter that is loaded from the threshold and steps once per accepted pair; when the counter reaches zero, one pair is replaced and the counter reloads. One-shot mode counts the same way, replaces exactly one pair and then clears its own enable, so the mode reads back as off. A read strobe copies the current counter value into a snapshot output for the host.

Both stream sides use valid/ready handshakes. The output side has a single register stage. An input pair is accepted when `s_ready` is high, which is whenever the output register is empty or is being drained in the same cycle. While `m_valid` is high and `m_ready` is low, the output pair is held unchanged and no input is accepted. The counter steps only on accepted pairs, so back-pressure never shifts where an injection falls.

Top module: `symbol_injector`

## Requirements
- R1: After reset, `m_valid` is 0, `s_ready` is 1, `mode_now` is 00 and `cnt_snap` is 0.
- R2: With mode 00 (off), every accepted pair appears on `m_pair` unchanged.
- R3: With mode 11 (continuous), every accepted pair is replaced by `{sym_a, sym_b}`, with `sym_a` in bits 9:5 and `sym_b` in bits 4:0.
- R4: With mode 10 (periodic) and threshold T > 0, the first T pairs after the mode write pass unchanged, the next pair is replaced, and this repeats with a period of T+1 pairs.
- R5: With mode 10 and threshold 0, every pair is replaced.
- R6: With mode 01 (one-shot) and threshold T, pairs 0 to T-1 after the mode write pass, pair T is replaced, and `mode_now` then reads 00 and no further pair is replaced.
- R7: A pulse on `cfg_wr` loads `cfg_mode` into `mode_now` and reloads the injection counter from `cfg_thresh`. This restarts the count from a new write even while an injection is pending.
- R8: A pulse on `cnt_rd` copies the counter value of that cycle into `cnt_snap` at the next clock edge. Without a pulse, `cnt_snap` holds its value.
- R9: When `m_valid` is 1 and `m_ready` is 0, `s_ready` is 0 and `m_pair` stays stable. The counter advances only on accepted pairs.
- R10: An accepted pair appears on `m_pair` with `m_valid` high one clock after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input pair valid |
| s_ready | output | 1 | Block can accept an input pair |
| s_pair | input | 10 | Input symbol pair, first symbol in bits 9:5 |
| m_valid | output | 1 | Output pair valid |
| m_ready | input | 1 | Downstream accepts the output pair |
| m_pair | output | 10 | Output pair, possibly replaced |
| sym_a | input | 5 | First replacement code group |
| sym_b | input | 5 | Second replacement code group |
| cfg_mode | input | 2 | Mode to write: 00 off, 01 one-shot, 10 periodic, 11 continuous |
| cfg_thresh | input | 8 | Injection threshold |
| cfg_wr | input | 1 | Write strobe for mode and counter reload |
| cnt_rd | input | 1 | Counter snapshot strobe |
| cnt_snap | output | 8 | Captured counter value |
| mode_now | output | 2 | Current mode, cleared to 00 after a one-shot injection |

## Verification
The continuous-mode property assumes that `sym_a` and `sym_b` hold steady for at least one cycle around each accepted pair, and that `cfg_wr` is not pulsed in the same cycle as a pair it is meant to affect. The stimulus follows both rules: it changes the symbols and the threshold only while `s_valid` is low, and it issues each mode write as an isolated one-cycle pulse with no pair present. The hold-under-stall property assumes nothing about the upstream side, so the stimulus deliberately presents a new pair during a stall to show that the pair is not taken.

// File: rtl/inj_pkg.sv
package inj_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ONCE = 2'b01,
    MODE_PER  = 2'b10,
    MODE_CONT = 2'b11
  } inj_mode_e;
endpackage

// File: rtl/inj_ctl.sv
module inj_ctl
  import inj_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [1:0]       cfg_mode,
  input  logic [CNT_W-1:0] cfg_thresh,
  input  logic             cfg_wr,
  output logic             inj,
  output logic [CNT_W-1:0] cnt,
  output logic [1:0]       mode
);
  inj_mode_e        mode_q, mode_nx;
  logic [CNT_W-1:0] cnt_q, cnt_nx;

  always_comb begin
    inj     = 1'b0;
    cnt_nx  = cnt_q;
    mode_nx = mode_q;
    if (fire) begin
      case (mode_q)
        MODE_OFF:  inj = 1'b0;
        MODE_CONT: inj = 1'b1;
        default: begin
          if (cnt_q == '0) begin
            inj    = 1'b1;
            cnt_nx = cfg_thresh;
            if (mode_q == MODE_ONCE) mode_nx = MODE_OFF;
          end else begin
            cnt_nx = cnt_q - 1'b1;
          end
        end
      endcase
    end
    if (cfg_wr) begin
      mode_nx = inj_mode_e'(cfg_mode);
      cnt_nx  = cfg_thresh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= MODE_OFF;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_nx;
      cnt_q  <= cnt_nx;
    end
  end

  assign cnt  = cnt_q;
  assign mode = mode_q;

  // R6: a one-shot injection clears the mode
  a_r6_once_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_q == MODE_ONCE && cnt_q == '0 && !cfg_wr) |=> (mode_q == MODE_OFF));
  // R2: with injection off and no write, the counter does not move
  a_r2_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_OFF && !cfg_wr) |=> $stable(cnt_q));
  // R9: the counter moves only on an accepted pair or a write
  a_r9_cnt_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !cfg_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/inj_sel.sv
module inj_sel #(
  parameter int SYM_W = 5,
  parameter int NSYM  = 2
) (
  input  logic [NSYM*SYM_W-1:0] din,
  input  logic [NSYM*SYM_W-1:0] rep,
  input  logic                  inj,
  output logic [NSYM*SYM_W-1:0] dout
);
  for (genvar g = 0; g < NSYM; g++) begin : g_lane
    assign dout[g*SYM_W +: SYM_W] = inj ? rep[g*SYM_W +: SYM_W] : din[g*SYM_W +: SYM_W];
  end
endmodule

// File: rtl/inj_snap.sv
module inj_snap #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] snap
);
  always_ff @(posedge clk) begin
    if (!rst_n)  snap <= '0;
    else if (rd) snap <= cnt;
  end

  // R8: the snapshot holds between read strobes
  a_r8_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(snap));
endmodule

// File: rtl/inj_stage.sv
module inj_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R9: a stalled output holds its pair
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R10: an accepted pair is presented on the next cycle
  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
endmodule

// File: rtl/symbol_injector.sv
module symbol_injector
  import inj_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter int CNT_W = 8,
  localparam int PAIR_W = 2 * SYM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PAIR_W-1:0] s_pair,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [PAIR_W-1:0] m_pair,
  input  logic [SYM_W-1:0]  sym_a,
  input  logic [SYM_W-1:0]  sym_b,
  input  logic [1:0]        cfg_mode,
  input  logic [CNT_W-1:0]  cfg_thresh,
  input  logic              cfg_wr,
  input  logic              cnt_rd,
  output logic [CNT_W-1:0]  cnt_snap,
  output logic [1:0]        mode_now
);
  logic              fire, inj;
  logic [CNT_W-1:0]  cnt;
  logic [PAIR_W-1:0] sel_pair;

  assign fire = s_valid && s_ready;

  inj_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .fire(fire), .cfg_mode(cfg_mode),
    .cfg_thresh(cfg_thresh), .cfg_wr(cfg_wr), .inj(inj), .cnt(cnt), .mode(mode_now)
  );

  inj_sel #(.SYM_W(SYM_W), .NSYM(2)) u_sel (
    .din(s_pair), .rep({sym_a, sym_b}), .inj(inj), .dout(sel_pair)
  );

  inj_stage #(.W(PAIR_W)) u_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_ready(s_ready), .in_data(sel_pair),
    .out_valid(m_valid), .out_ready(m_ready), .out_data(m_pair)
  );

  inj_snap #(.CNT_W(CNT_W)) u_snap (
    .clk(clk), .rst_n(rst_n), .rd(cnt_rd), .cnt(cnt), .snap(cnt_snap)
  );

  // R3: continuous mode replaces an accepted pair with the programmed symbols
  a_r3_cont_replace: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_now == 2'b11 && !cfg_wr) |=> (m_pair == $past({sym_a, sym_b})));
  // R2: off mode forwards the accepted pair untouched
  a_r2_off_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode_now == 2'b00) |=> (m_pair == $past(s_pair)));
endmodule

// File: tb/sim_symbol_injector.sv
module sim_symbol_injector;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_valid = 1'b0, s_ready, m_valid, m_ready = 1'b1;
  logic [9:0] s_pair = '0, m_pair;
  logic [4:0] sym_a = 5'b11000, sym_b = 5'b10001;
  logic [1:0] cfg_mode = 2'b00, mode_now;
  logic [7:0] cfg_thresh = '0, cnt_snap;
  logic       cfg_wr = 1'b0, cnt_rd = 1'b0;

  int checks = 0, fails = 0, cycles = 0;
  logic [1:0] mmode;
  logic [7:0] mcnt;

  // Entries: {mode, threshold}
  localparam logic [9:0] VEC [8] = '{
    {2'b00, 8'd3}, {2'b11, 8'd0}, {2'b10, 8'd2}, {2'b10, 8'd0},
    {2'b01, 8'd2}, {2'b01, 8'd0}, {2'b10, 8'd3}, {2'b11, 8'd5}
  };

  always #10 clk = ~clk;

  symbol_injector u0 (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_pair(s_pair),
    .m_valid(m_valid), .m_ready(m_ready), .m_pair(m_pair), .sym_a(sym_a), .sym_b(sym_b),
    .cfg_mode(cfg_mode), .cfg_thresh(cfg_thresh), .cfg_wr(cfg_wr), .cnt_rd(cnt_rd),
    .cnt_snap(cnt_snap), .mode_now(mode_now)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] md, input logic [7:0] th);
    s_valid = 1'b0; cfg_mode = md; cfg_thresh = th; cfg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
    mmode = md; mcnt = th;
  endtask

  // Model of R2..R6: expected result for one accepted pair
  function automatic logic [9:0] model(input logic [9:0] d);
    logic rep;
    rep = 1'b0;
    case (mmode)
      2'b00: rep = 1'b0;
      2'b11: rep = 1'b1;
      default: if (mcnt == 0) begin
        rep = 1'b1; mcnt = cfg_thresh;
        if (mmode == 2'b01) mmode = 2'b00;
      end else mcnt = mcnt - 1;
    endcase
    return rep ? {sym_a, sym_b} : d;
  endfunction

  task automatic send(input string req, input logic [9:0] d);
    logic [9:0] exp;
    exp = model(d);
    s_valid = 1'b1; s_pair = d;
    @(posedge clk); @(negedge clk);
    check({req, "/R10 valid"}, m_valid, 1);
    check(req, m_pair, exp);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 m_valid", m_valid, 0);
    check("R1 s_ready", s_ready, 1);
    check("R1 mode", mode_now, 0);
    check("R1 snap", cnt_snap, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk covering R2..R7
    for (int e = 0; e < 8; e++) begin
      configure(VEC[e][9:8], VEC[e][7:0]);
      check("R7 mode load", mode_now, VEC[e][9:8]);
      case (VEC[e][9:8])
        2'b00: tag = "R2";
        2'b11: tag = "R3";
        2'b10: tag = (VEC[e][7:0] == 0) ? "R5" : "R4";
        default: tag = "R6";
      endcase
      for (int i = 0; i < 8; i++) send(tag, 10'(e * 37 + i * 5 + 1));
      s_valid = 1'b0;
      if (VEC[e][9:8] == 2'b01) check("R6 mode cleared", mode_now, 0);
    end

    // R7: a new write restarts a pending one-shot count
    configure(2'b01, 8'd3);
    send("R7", 10'h011);
    send("R7", 10'h012);
    configure(2'b01, 8'd1);
    send("R7", 10'h013);
    send("R7", 10'h014);
    send("R7", 10'h015);
    s_valid = 1'b0;

    // R8: snapshot of the counter
    configure(2'b10, 8'd5);
    send("R4", 10'h021);
    send("R4", 10'h022);
    s_valid = 1'b0; cnt_rd = 1'b1;
    @(posedge clk); @(negedge clk);
    cnt_rd = 1'b0;
    check("R8 snapshot", cnt_snap, 3);
    send("R4", 10'h023);
    s_valid = 1'b0;
    check("R8 hold", cnt_snap, 3);

    // R9: back-pressure, counter steps only on accepted pairs
    configure(2'b10, 8'd1);
    m_ready = 1'b0;
    send("R9", 10'h0A1);
    s_pair = 10'h0B2; s_valid = 1'b1;
    check("R9 s_ready low", s_ready, 0);
    @(posedge clk); @(negedge clk);
    check("R9 held pair", m_pair, 10'h0A1);
    check("R9 held valid", m_valid, 1);
    m_ready = 1'b1;
    send("R9", 10'h0B2);
    s_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 drained", m_valid, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule